// File: doc/BRIEF.md
# Load/Store Single-Transfer Execution Unit

This block carries out one load or store of a word or a byte for a 32-bit register-based processor. An upstream decoder hands it the low 26 bits of an instruction with a one-cycle `start` pulse. The unit addresses three register-file read ports straight from those bits: the base, the data/destination and the offset register. It forms an offset, which is either a 12-bit immediate or a shifted register, and adds it to or subtracts it from the base. It picks the pre- or post-indexed address and issues exactly one request on a simple request/acknowledge memory bus.

After the acknowledge, the unit presents its register-file writes for one cycle together with a `done` pulse. A load writes the formatted data to the destination. The updated base is written when the indexing mode asks for it. Word stores are forced onto a word boundary. Word loads from a misaligned address return the aligned word rotated, so that the addressed byte sits in the low lane. Condition evaluation, privilege handling, exceptions and the register file itself stay outside the block.

Top module: `ldst_unit`

## Requirements
- R1: The read-port selects are driven combinationally from `instr`: base select = bits [19:16], data select = bits [15:12], offset-register select = bits [3:0]. Control bits are I = bit 25, P = 24, U = 23, B = 22, W = 21, L = 20. `start` is sampled only while the unit is idle.
- R2: With I = 0 the offset is bits [11:0], zero-extended to 32 bits.
- R3: With I = 1 the offset is the offset register shifted by bits [11:7] using the kind in bits [6:5]: 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right. An amount of 0 passes the register unchanged. No flag leaves the block.
- R4: U = 1 forms base + offset and U = 0 forms base − offset, both modulo 2^32.
- R5: P = 1 transfers at the modified base (pre-index). P = 0 transfers at the unmodified base (post-index).
- R6: The modified base is written to the base register when P = 0, or when P = 1 and W = 1. Otherwise no base write occurs.
- R7: A word store (L = 0, B = 0) drives `memAddr` with bits [1:0] cleared, `memByte` = 0, and the full data register on `memWdata`.
- R8: A byte store (L = 0, B = 1) drives the unaligned address, `memByte` = 1, and `memWdata` = {24'b0, data[7:0]}.
- R9: A word load requests the aligned address. The result is the returned word rotated right by 8 × address[1:0].
- R10: A byte load requests the unaligned address with `memByte` = 1. Memory returns the byte in `memRdata[7:0]`, and the result is that byte zero-extended.
- R11: When a load writes back a base register that equals its destination, only the loaded value is written (`baseWe` stays low).
- R12: Each instruction raises `memReq` in the cycle after `start` and holds it, with stable fields, until `memAck`. That makes exactly one request. `done` and the write strobes are high for exactly the one cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (idle only) |
| instr | input | 26 | Instruction bits [25:0] |
| rnSel | output | 4 | Base register read select |
| rnData | input | 32 | Base register value |
| rdSel | output | 4 | Data register read select |
| rdData | input | 32 | Data register value |
| rmSel | output | 4 | Offset register read select |
| rmData | input | 32 | Offset register value |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memByte | output | 1 | 1 = byte access, 0 = word |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load data, valid with acknowledge |
| memAck | input | 1 | Memory acknowledge |
| done | output | 1 | Instruction complete pulse |
| loadWe | output | 1 | Destination write strobe |
| loadIdx | output | 4 | Destination register index |
| loadVal | output | 32 | Destination write data |
| baseWe | output | 1 | Base write strobe |
| baseIdx | output | 4 | Base register index |
| baseVal | output | 32 | Updated base value |

## Verification
The bench drives word loads at all four byte offsets. A design that rotated the wrong way, or by bytes instead of bits, would return a scrambled word. It also drives word stores at odd addresses, which a missing alignment mask would leak onto the bus.

It covers each shift kind, including amount zero and an arithmetic shift of a negative register. Subtractions are chosen to wrap below zero and additions to wrap past 2^32, so a truncated or sign-confused adder shows up as a wrong address or base.

Post-indexed loads that reuse the base as destination expose a design that double-writes or lets the base win. A `start` pulse held during a stalled request would make a design that does not ignore it issue a second request.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  parameter int XLEN  = 32;
  parameter int IDX_W = 4;
  parameter int IN_W  = 26;

  localparam int SH_W   = $clog2(XLEN);
  localparam int BYTE_W = 8;
  localparam int LANE_W = $clog2(XLEN / BYTE_W);

  // control-bit positions inside the instruction word
  localparam int POS_I = 25;
  localparam int POS_P = 24;
  localparam int POS_U = 23;
  localparam int POS_B = 22;
  localparam int POS_W = 21;
  localparam int POS_L = 20;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_t;

  typedef struct packed {
    logic capture;   // latch operands and address
    logic takeLoad;  // latch returned memory data
    logic finish;    // present register writes
  } ctrlStrobes_t;
endpackage

// File: rtl/ldst_shifter.sv
module ldst_shifter
  import ldst_pkg::*;
(
  input  logic [XLEN-1:0] value,
  input  shiftKind_t      kind,
  input  logic [SH_W-1:0] amount,
  output logic [XLEN-1:0] result
);
  always_comb begin
    unique case (kind)
      SH_LSL: result = value << amount;
      SH_LSR: result = value >> amount;
      SH_ASR: result = XLEN'($signed(value) >>> amount);
      SH_ROR: result = (value >> amount) | (value << (XLEN - int'(amount)));
      default: result = value;
    endcase
  end
endmodule

// File: rtl/ldst_control.sv
module ldst_control
  import ldst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         memAck,
  output ctrlStrobes_t strobe,
  output logic         memReq,
  output logic         done
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DONE} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start)  stateNext = ST_REQ;
      ST_REQ:  if (memAck) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign strobe.capture  = (state == ST_IDLE) && start;
  assign strobe.takeLoad = (state == ST_REQ) && memAck;
  assign strobe.finish   = (state == ST_DONE);
  assign memReq          = (state == ST_REQ);
  assign done            = (state == ST_DONE);

  // R12: request stays up until acknowledged
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq);
  // R12: acknowledge ends the request and completes the instruction
  p_single_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memAck |=> !memReq && done);
  // R12: completion is a one-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobe,
  input  logic [IN_W-1:0]  instr,
  input  logic [XLEN-1:0]  rnData,
  input  logic [XLEN-1:0]  rdData,
  input  logic [XLEN-1:0]  rmData,
  input  logic [XLEN-1:0]  memRdata,
  output logic             memWe,
  output logic             memByte,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic             loadWe,
  output logic [IDX_W-1:0] loadIdx,
  output logic [XLEN-1:0]  loadVal,
  output logic             baseWe,
  output logic [IDX_W-1:0] baseIdx,
  output logic [XLEN-1:0]  baseVal
);
  // ---- operand and address formation (combinational, from live inputs)
  logic [XLEN-1:0] offImm, offReg, offset, modBase, xferAddrD;
  logic            wantWb;

  assign offImm = {{(XLEN-12){1'b0}}, instr[11:0]};

  ldst_shifter u_shift (
    .value  (rmData),
    .kind   (shiftKind_t'(instr[6:5])),
    .amount (instr[7 +: SH_W]),
    .result (offReg)
  );

  assign offset    = instr[POS_I] ? offReg : offImm;
  assign modBase   = instr[POS_U] ? (rnData + offset) : (rnData - offset);
  assign xferAddrD = instr[POS_P] ? modBase : rnData;
  assign wantWb    = !instr[POS_P] || instr[POS_W];

  // ---- latched instruction state
  logic [XLEN-1:0]  xferAddrQ, newBaseQ, storeQ, loadQ;
  logic [IDX_W-1:0] rnQ, rdQ;
  logic             isLoadQ, isByteQ, wbQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xferAddrQ <= '0;
      newBaseQ  <= '0;
      storeQ    <= '0;
      rnQ       <= '0;
      rdQ       <= '0;
      isLoadQ   <= 1'b0;
      isByteQ   <= 1'b0;
      wbQ       <= 1'b0;
    end else if (strobe.capture) begin
      xferAddrQ <= xferAddrD;
      newBaseQ  <= modBase;
      storeQ    <= rdData;
      rnQ       <= instr[19:16];
      rdQ       <= instr[15:12];
      isLoadQ   <= instr[POS_L];
      isByteQ   <= instr[POS_B];
      wbQ       <= wantWb;
    end
  end

  // ---- memory side
  logic [SH_W-1:0] rotAmt;
  logic [XLEN-1:0] wordRot, byteExt;

  assign memWe    = !isLoadQ;
  assign memByte  = isByteQ;
  assign memAddr  = isByteQ ? xferAddrQ
                            : {xferAddrQ[XLEN-1:LANE_W], {LANE_W{1'b0}}};
  assign memWdata = isByteQ ? {{(XLEN-BYTE_W){1'b0}}, storeQ[BYTE_W-1:0]}
                            : storeQ;

  assign rotAmt  = SH_W'({xferAddrQ[LANE_W-1:0], 3'b000});
  assign wordRot = (memRdata >> rotAmt) | (memRdata << (XLEN - int'(rotAmt)));
  assign byteExt = {{(XLEN-BYTE_W){1'b0}}, memRdata[BYTE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               loadQ <= '0;
    else if (strobe.takeLoad) loadQ <= isByteQ ? byteExt : wordRot;
  end

  // ---- register-file write side
  assign loadWe  = strobe.finish && isLoadQ;
  assign loadIdx = rdQ;
  assign loadVal = loadQ;
  assign baseWe  = strobe.finish && wbQ && !(isLoadQ && (rnQ == rdQ));
  assign baseIdx = rnQ;
  assign baseVal = newBaseQ;

  // R11: never two writes to one register in the same cycle
  p_no_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loadWe && baseWe |-> loadIdx != baseIdx);
  // R10: a byte load result carries nothing above the low byte
  p_byte_zext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loadWe && memByte |-> loadVal[XLEN-1:BYTE_W] == '0);
  // R6: write strobes appear only in the completion cycle
  p_wr_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loadWe || baseWe) |=> !(loadWe || baseWe));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IN_W-1:0]  instr,
  output logic [IDX_W-1:0] rnSel,
  input  logic [XLEN-1:0]  rnData,
  output logic [IDX_W-1:0] rdSel,
  input  logic [XLEN-1:0]  rdData,
  output logic [IDX_W-1:0] rmSel,
  input  logic [XLEN-1:0]  rmData,
  output logic             memReq,
  output logic             memWe,
  output logic             memByte,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  input  logic [XLEN-1:0]  memRdata,
  input  logic             memAck,
  output logic             done,
  output logic             loadWe,
  output logic [IDX_W-1:0] loadIdx,
  output logic [XLEN-1:0]  loadVal,
  output logic             baseWe,
  output logic [IDX_W-1:0] baseIdx,
  output logic [XLEN-1:0]  baseVal
);
  ctrlStrobes_t strobe;

  assign rnSel = instr[19:16];
  assign rdSel = instr[15:12];
  assign rmSel = instr[3:0];

  ldst_control u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .memAck (memAck),
    .strobe (strobe),
    .memReq (memReq),
    .done   (done)
  );

  ldst_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .instr    (instr),
    .rnData   (rnData),
    .rdData   (rdData),
    .rmData   (rmData),
    .memRdata (memRdata),
    .memWe    (memWe),
    .memByte  (memByte),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .loadWe   (loadWe),
    .loadIdx  (loadIdx),
    .loadVal  (loadVal),
    .baseWe   (baseWe),
    .baseIdx  (baseIdx),
    .baseVal  (baseVal)
  );

  // R7: word writes never leave the word boundary
  p_store_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memWe && !memByte |-> memAddr[1:0] == 2'b00);
  // R12: request fields hold while waiting for acknowledge
  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWe) && $stable(memByte));
endmodule

// File: tb/tb_ldst_unit.sv
`timescale 1ns/1ps
module tb_ldst_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [25:0] instr = '0;
  logic [3:0]  rnSel, rdSel, rmSel;
  logic [31:0] rnData, rdData, rmData;
  logic        memReq, memWe, memByte, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic        done, loadWe, baseWe;
  logic [3:0]  loadIdx, baseIdx;
  logic [31:0] loadVal, baseVal;

  logic [31:0] regFile [16];
  int vectors = 0;
  int misses  = 0;
  int accepts = 0;

  always #2.5 clk = ~clk;

  assign rnData = regFile[rnSel];
  assign rdData = regFile[rdSel];
  assign rmData = regFile[rmSel];

  ldst_unit dut (.*);

  always @(posedge clk) if (memReq && memAck) accepts++;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr(logic [31:0] x, int n);
    if (n == 0) return x;
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [25:0] mk(bit i, bit p, bit u, bit b, bit w, bit l,
                                     logic [3:0] rn, logic [3:0] rd, logic [11:0] low);
    return {i, p, u, b, w, l, rn, rd, low};
  endfunction

  // shifted-register offset field: amount, kind, register
  function automatic logic [11:0] so(int amt, int kind, logic [3:0] rm);
    return {amt[4:0], kind[1:0], 1'b0, rm};
  endfunction

  // Runs one instruction and checks everything against the requirement model.
  task automatic runOp(string tag, logic [25:0] ins, logic [31:0] memWord,
                       int lat, bit poke);
    logic [31:0] b, d, off, modB, a, eAddr, eWdata, eLoad;
    logic [31:0] rm;
    int amt;
    bit l, by, wb;
    int acc0;
    logic [31:0] gotAddr;

    b  = regFile[ins[19:16]];
    d  = regFile[ins[15:12]];
    rm = regFile[ins[3:0]];
    amt = int'(ins[11:7]);
    if (ins[25]) begin
      case (ins[6:5])
        2'b00: off = rm << amt;
        2'b01: off = rm >> amt;
        2'b10: off = 32'($signed(rm) >>> amt);
        default: off = rotr(rm, amt);
      endcase
    end else off = {20'h0, ins[11:0]};
    modB = ins[23] ? b + off : b - off;
    a    = ins[24] ? modB : b;
    l    = ins[20];
    by   = ins[22];
    wb   = !ins[24] || ins[21];
    eAddr  = by ? a : {a[31:2], 2'b00};
    eWdata = by ? {24'h0, d[7:0]} : d;
    eLoad  = by ? {24'h0, memWord[7:0]} : rotr(memWord, 8 * int'(a[1:0]));
    acc0 = accepts;

    @(negedge clk);
    instr = ins; start = 1'b1;
    #0.5;
    chk({tag, "/R1"}, "rnSel", 32'(rnSel), 32'(ins[19:16]));
    chk({tag, "/R1"}, "rdSel", 32'(rdSel), 32'(ins[15:12]));
    chk({tag, "/R1"}, "rmSel", 32'(rmSel), 32'(ins[3:0]));
    @(negedge clk);
    start = 1'b0;
    chk({tag, "/R12"}, "memReq", 32'(memReq), 32'd1);
    chk(tag, "memAddr", memAddr, eAddr);
    chk(tag, "memWe", 32'(memWe), 32'(!l));
    chk(tag, "memByte", 32'(memByte), 32'(by));
    if (!l) chk(tag, "memWdata", memWdata, eWdata);
    gotAddr = memAddr;
    for (int k = 0; k < lat; k++) begin
      if (poke) begin start = 1'b1; instr = ~ins; end
      @(negedge clk);
      chk({tag, "/R12"}, "held memReq", 32'(memReq), 32'd1);
      chk({tag, "/R12"}, "held memAddr", memAddr, gotAddr);
    end
    start = 1'b0; instr = ins;
    memAck = 1'b1; memRdata = memWord;
    @(negedge clk);
    memAck = 1'b0; memRdata = 32'hDEAD_BEEF;
    chk({tag, "/R12"}, "done", 32'(done), 32'd1);
    chk({tag, "/R12"}, "memReq after ack", 32'(memReq), 32'd0);
    chk(tag, "loadWe", 32'(loadWe), 32'(l));
    if (l) begin
      chk(tag, "loadIdx", 32'(loadIdx), 32'(ins[15:12]));
      chk(tag, "loadVal", loadVal, eLoad);
    end
    chk({tag, "/R6/R11"}, "baseWe", 32'(baseWe),
        32'(wb && !(l && ins[19:16] == ins[15:12])));
    if (baseWe) begin
      chk({tag, "/R6"}, "baseIdx", 32'(baseIdx), 32'(ins[19:16]));
      chk({tag, "/R6"}, "baseVal", baseVal, modB);
    end
    @(negedge clk);
    chk({tag, "/R12"}, "done pulse end", 32'(done), 32'd0);
    chk({tag, "/R12"}, "no second req", 32'(memReq), 32'd0);
    chk({tag, "/R12"}, "strobes low", 32'({loadWe, baseWe}), 32'd0);
    chk({tag, "/R12"}, "one request", 32'(accepts - acc0), 32'd1);
  endtask

  task automatic testReset();
    chk("R12", "reset memReq", 32'(memReq), 32'd0);
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R6", "reset write strobes", 32'({loadWe, baseWe}), 32'd0);
  endtask

  task automatic testWordLoads();
    // R2 R4 R5 R9: pre-index add, immediate, every byte lane
    for (int lane = 0; lane < 4; lane++)
      runOp("R9", mk(0, 1, 1, 0, 0, 1, 4'd1, 4'd2, 12'h020 + 12'(lane)),
            32'hA1B2_C3D4, 0, 0);
    // explicit spot check of one rotation (address 0x1021 -> one byte)
    runOp("R9", mk(0, 1, 1, 0, 0, 1, 4'd1, 4'd2, 12'h021), 32'hA1B2_C3D4, 1, 0);
    chk("R9", "rotated word literal", loadVal, 32'hD4A1_B2C3);
  endtask

  task automatic testByteLoad();
    runOp("R10", mk(0, 1, 1, 1, 0, 1, 4'd1, 4'd3, 12'h003), 32'hFFFF_FF9C, 2, 0);
    chk("R10", "zero-extended literal", loadVal, 32'h0000_009C);
  endtask

  task automatic testStores();
    // R7 R6: misaligned word store, pre-index with writeback
    runOp("R7", mk(0, 1, 1, 0, 1, 0, 4'd1, 4'd5, 12'h006), 32'h0, 0, 0);
    chk("R7", "aligned literal", memAddr, 32'h0000_1004);
    // R8 R4 R5: byte store, post-index subtract wrapping below zero
    runOp("R8", mk(0, 0, 0, 1, 0, 0, 4'd6, 4'd5, 12'h010), 32'h0, 1, 0);
    chk("R4", "wrapped base literal", baseVal, 32'hFFFF_FFF4);
    // R2: large immediate, pre-index subtract, no writeback
    runOp("R2", mk(0, 1, 0, 0, 0, 0, 4'd1, 4'd5, 12'hFFF), 32'h0, 0, 0);
  endtask

  task automatic testRegOffsets();
    // R3: each shift kind, amount zero, negative arithmetic shift
    runOp("R3", mk(1, 1, 1, 0, 1, 1, 4'd1, 4'd2, so(4, 0, 4'd7)), 32'h1234_5678, 0, 0);
    runOp("R3", mk(1, 1, 1, 0, 1, 1, 4'd1, 4'd2, so(3, 1, 4'd8)), 32'h1234_5678, 0, 0);
    runOp("R3", mk(1, 1, 0, 0, 1, 1, 4'd1, 4'd2, so(28, 2, 4'd8)), 32'h1234_5678, 0, 0);
    runOp("R3", mk(1, 0, 1, 0, 0, 0, 4'd9, 4'd5, so(8, 3, 4'd7)), 32'h0, 0, 0);
    runOp("R3", mk(1, 1, 1, 1, 0, 1, 4'd1, 4'd2, so(0, 1, 4'd7)), 32'h0000_0055, 0, 0);
    // R4: addition wraps past 2^32
    runOp("R4", mk(0, 1, 1, 0, 1, 0, 4'd9, 4'd5, 12'h020), 32'h0, 0, 0);
  endtask

  task automatic testSameReg();
    // R11: post-index load with base == destination
    runOp("R11", mk(0, 0, 1, 0, 0, 1, 4'd1, 4'd1, 12'h008), 32'hCAFE_F00D, 0, 0);
    chk("R11", "load value wins", loadVal, 32'hCAFE_F00D);
    // R6: pre-index without W never writes the base
    runOp("R6", mk(0, 1, 1, 0, 0, 1, 4'd1, 4'd2, 12'h004), 32'h0BAD_0BAD, 0, 0);
  endtask

  task automatic testStartIgnored();
    // R12: start held during a stalled request must not launch anything
    runOp("R12", mk(0, 1, 1, 0, 0, 1, 4'd1, 4'd2, 12'h010), 32'h7777_1111, 3, 1);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) regFile[r] = 32'h1111_0000 * r;
    regFile[1] = 32'h0000_1000;
    regFile[5] = 32'h89AB_CDEF;
    regFile[6] = 32'h0000_0004;
    regFile[7] = 32'h0000_0011;
    regFile[8] = 32'h8000_0040;
    regFile[9] = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testWordLoads();
    testByteLoad();
    testStores();
    testRegOffsets();
    testSameReg();
    testStartIgnored();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule